// File: doc/BRIEF.md
# Decoder Stream Feed Port

This block sits between a transport demultiplexer and two compressed-stream decoders, one for video and one for audio. The demultiplexer fills two byte FIFOs, and the port drains them toward the decoders over a single shared 8-bit data bus. Each decoder asks for data by pulling its active-low request line. The port answers with one byte at a time, and marks each byte with an active-low strobe whose rising edge is the decoder's latch point. A video byte that carries a presentation or decoding timestamp is flagged by a separate active-high strobe.

Audio can be delivered in two ways. In byte mode it uses the shared bus in the same way as video. In bit mode each byte is shifted out, most-significant bit first, on a dedicated serial pin, and the audio strobe then pulses once per bit. When both decoders are waiting, grants alternate between them. The port also watches two asynchronous frame-start inputs. It synchronises them, and on a rising edge of either one it copies the running system time counter into a capture register.

Top module: `strm_feed_port`

## Requirements
- R1: A transfer for a decoder starts only in a cycle where that decoder's request input is low and its FIFO is not empty. Each start pops exactly one byte, and the pop is asserted in that start cycle.
- R2: A parallel byte transfer drives the byte on the bus in the cycle before its strobe falls. The strobe is low for exactly one clock. The byte is still driven, unchanged, in the clock after the strobe rises, and a strobe stays high for at least two clocks between pulses.
- R3: The bus output enable is high only during parallel transfers. It is low when the port is idle and during serial audio transfers, and the bus value is zero whenever the enable is low.
- R4: When the audio mode input is 0 at grant, an audio byte is transferred on the shared bus with a single audio strobe pulse, in the same way as video.
- R5: When the audio mode input is 1 at grant, an audio byte is sent on the serial output, most-significant bit first, with eight audio strobe pulses. Each bit is valid from the cycle before its pulse until the cycle after it.
- R6: When both decoders are eligible in the same idle cycle, the one that was not served last is granted, so a continuous joint demand gives strictly alternating video and audio bytes.
- R7: The timestamp strobe is high for the whole transfer of a video byte whose grant cycle saw the timestamp-pending input high, and it is low at all other times, including during every audio transfer.
- R8: A rising edge on either frame-start input is seen after two synchroniser flops. On the third clock edge after the input rises, the capture register loads the system time counter value present at that edge, and the capture pulse is high for one cycle. A level held high causes no further capture.
- R9: Rising edges on both frame-start inputs at the same time cause a single capture and a single capture pulse.
- R10: After reset both strobes are high, the output enable, serial output, timestamp strobe, pops and capture pulse are low, and the capture register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_req_n | input | 1 | Video decoder data request, active low |
| aud_req_n | input | 1 | Audio decoder data request, active low |
| aud_serial_mode | input | 1 | 1 selects bit-serial audio, 0 selects byte-parallel audio |
| vid_fifo_data | input | 8 | Head byte of the video FIFO (show-ahead) |
| vid_fifo_empty | input | 1 | Video FIFO has no byte |
| vid_fifo_pop | output | 1 | Consume the video FIFO head byte |
| aud_fifo_data | input | 8 | Head byte of the audio FIFO (show-ahead) |
| aud_fifo_empty | input | 1 | Audio FIFO has no byte |
| aud_fifo_pop | output | 1 | Consume the audio FIFO head byte |
| ts_pending | input | 1 | The current video head byte is a timestamp byte |
| frame_start0 | input | 1 | First asynchronous frame-start input |
| frame_start1 | input | 1 | Second asynchronous frame-start input |
| stc_value | input | 33 | Running system time counter |
| dbus_out | output | 8 | Shared decoder data bus value |
| dbus_oe | output | 1 | Drive enable for the shared bus (tri-state when low) |
| vid_strb_n | output | 1 | Video byte strobe, active low |
| aud_strb_n | output | 1 | Audio byte or bit strobe, active low |
| aud_ser_out | output | 1 | Serial audio data |
| ts_strb | output | 1 | Timestamp byte marker, active high |
| stc_capture | output | 33 | Captured system time counter value |
| stc_cap_stb | output | 1 | One-cycle pulse when a capture occurs |

## Verification
On every cycle the assertions check the strobe shape: a one-cycle low pulse, data held across the rising edge, and the two strobes never low together. They also check that pops never hit an empty FIFO, that the bus enable and timestamp strobe appear only during suitable transfers, and that every detected frame edge produces a capture on the next cycle. Only the bench scenarios can show the content: every byte reaching the right decoder in FIFO order, serial bits assembling to the right byte, the timestamp marking lining up with the marked bytes, grants alternating under joint demand, and the exact capture latency and value.

// File: rtl/strm_feed_pkg.sv
package strm_feed_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } xfer_st_e;

    typedef enum logic {
        CH_VID = 1'b0,
        CH_AUD = 1'b1
    } chan_e;
endpackage

// File: rtl/sfp_edge_sync.sv
module sfp_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = async_in;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rise = r_q.s2 & ~r_q.prev;

    // R8: a detected edge cannot repeat on the next cycle
    p_single_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sfp_time_capture.sv
module sfp_time_capture #(
    parameter int STC_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_a,
    input  logic             rise_b,
    input  logic [STC_W-1:0] stc_value,
    output logic [STC_W-1:0] capture,
    output logic             cap_stb
);
    typedef struct packed {
        logic [STC_W-1:0] cap;
        logic             stb;
    } cap_t;

    cap_t r_d, r_q;
    logic hit;

    assign hit = rise_a | rise_b;

    always_comb begin
        r_d     = r_q;
        r_d.stb = hit;
        if (hit) r_d.cap = stc_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign capture = r_q.cap;
    assign cap_stb = r_q.stb;

    p_edge_captures_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cap_stb && capture == $past(stc_value)));
    p_capture_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(capture));
    // R9: a double edge still gives one pulse
    p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> !cap_stb);
endmodule

// File: rtl/sfp_xfer_engine.sv
module sfp_xfer_engine
    import strm_feed_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_req_n,
    input  logic              aud_req_n,
    input  logic              aud_serial_mode,
    input  logic [DATA_W-1:0] vid_fifo_data,
    input  logic              vid_fifo_empty,
    output logic              vid_fifo_pop,
    input  logic [DATA_W-1:0] aud_fifo_data,
    input  logic              aud_fifo_empty,
    output logic              aud_fifo_pop,
    input  logic              ts_pending,
    output logic [DATA_W-1:0] dbus_out,
    output logic              dbus_oe,
    output logic              vid_strb_n,
    output logic              aud_strb_n,
    output logic              aud_ser_out,
    output logic              ts_strb
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        xfer_st_e          st;
        chan_e             chan;
        chan_e             last;
        logic              serial;
        logic              ts;
        logic [DATA_W-1:0] dat;
        logic [CNT_W-1:0]  bitn;
    } eng_t;

    eng_t r_d, r_q;
    logic vid_ok, aud_ok, grant;
    chan_e pick;

    always_comb begin
        vid_ok = !vid_req_n && !vid_fifo_empty;
        aud_ok = !aud_req_n && !aud_fifo_empty;
        grant  = (r_q.st == ST_IDLE) && (vid_ok || aud_ok);
        if (vid_ok && aud_ok) pick = (r_q.last == CH_VID) ? CH_AUD : CH_VID;
        else if (vid_ok)      pick = CH_VID;
        else                  pick = CH_AUD;
    end

    always_comb begin
        r_d = r_q;
        vid_fifo_pop = 1'b0;
        aud_fifo_pop = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (grant) begin
                    r_d.st     = ST_SETUP;
                    r_d.chan   = pick;
                    r_d.bitn   = '0;
                    r_d.serial = (pick == CH_AUD) && aud_serial_mode;
                    r_d.ts     = (pick == CH_VID) && ts_pending;
                    r_d.dat    = (pick == CH_VID) ? vid_fifo_data : aud_fifo_data;
                    vid_fifo_pop = (pick == CH_VID);
                    aud_fifo_pop = (pick == CH_AUD);
                end
            end
            ST_SETUP: r_d.st = ST_LOW;
            ST_LOW:   r_d.st = ST_HIGH;
            ST_HIGH: begin
                if (r_q.serial && r_q.bitn != LAST_BIT) begin
                    r_d.st   = ST_SETUP;
                    r_d.bitn = r_q.bitn + 1'b1;
                    r_d.dat  = {r_q.dat[DATA_W-2:0], 1'b0};
                end else begin
                    r_d.st     = ST_IDLE;
                    r_d.ts     = 1'b0;
                    r_d.serial = 1'b0;
                    r_d.last   = r_q.chan;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.last <= CH_AUD;
        end else begin
            r_q <= r_d;
        end
    end

    logic busy;
    assign busy        = (r_q.st != ST_IDLE);
    assign dbus_oe     = busy && !r_q.serial;
    assign dbus_out    = dbus_oe ? r_q.dat : '0;
    assign aud_ser_out = busy && r_q.serial && r_q.dat[DATA_W-1];
    assign vid_strb_n  = !((r_q.st == ST_LOW) && (r_q.chan == CH_VID));
    assign aud_strb_n  = !((r_q.st == ST_LOW) && (r_q.chan == CH_AUD));
    assign ts_strb     = r_q.ts;

    // R1: pops only from a non-empty, requesting channel
    p_vid_pop_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vid_fifo_pop |-> (!vid_fifo_empty && !vid_req_n));
    p_aud_pop_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
        aud_fifo_pop |-> (!aud_fifo_empty && !aud_req_n));
    p_pop_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(vid_fifo_pop && aud_fifo_pop));
    // R2: one-clock pulses with data held over the rising edge
    p_vstrb_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_strb_n |=> vid_strb_n);
    p_vstrb_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_strb_n) |=> vid_strb_n);
    p_vdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_strb_n |=> ($stable(dbus_out) && dbus_oe));
    p_strb_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vid_strb_n || aud_strb_n);
    // R3: no bus drive while a strobe is high and no transfer runs
    p_bus_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dbus_oe |-> (dbus_out == '0));
    // R5: serial bit held over the audio strobe rising edge
    p_abit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!aud_strb_n && !dbus_oe) |=> $stable(aud_ser_out));
    p_astrb_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !aud_strb_n |=> aud_strb_n);
    // R7: timestamp marker never accompanies audio
    p_ts_video_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ts_strb |-> (aud_strb_n && dbus_oe));
endmodule

// File: rtl/strm_feed_port.sv
module strm_feed_port #(
    parameter int DATA_W = 8,
    parameter int STC_W  = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_req_n,
    input  logic              aud_req_n,
    input  logic              aud_serial_mode,
    input  logic [DATA_W-1:0] vid_fifo_data,
    input  logic              vid_fifo_empty,
    output logic              vid_fifo_pop,
    input  logic [DATA_W-1:0] aud_fifo_data,
    input  logic              aud_fifo_empty,
    output logic              aud_fifo_pop,
    input  logic              ts_pending,
    input  logic              frame_start0,
    input  logic              frame_start1,
    input  logic [STC_W-1:0]  stc_value,
    output logic [DATA_W-1:0] dbus_out,
    output logic              dbus_oe,
    output logic              vid_strb_n,
    output logic              aud_strb_n,
    output logic              aud_ser_out,
    output logic              ts_strb,
    output logic [STC_W-1:0]  stc_capture,
    output logic              stc_cap_stb
);
    localparam int N_FRAME = 2;

    logic [N_FRAME-1:0] frame_in;
    logic [N_FRAME-1:0] frame_rise;

    assign frame_in = {frame_start1, frame_start0};

    for (genvar g = 0; g < N_FRAME; g++) begin : g_fsync
        sfp_edge_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (frame_in[g]),
            .rise     (frame_rise[g])
        );
    end

    sfp_time_capture #(.STC_W(STC_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_a    (frame_rise[0]),
        .rise_b    (frame_rise[1]),
        .stc_value (stc_value),
        .capture   (stc_capture),
        .cap_stb   (stc_cap_stb)
    );

    sfp_xfer_engine #(.DATA_W(DATA_W)) u_eng (
        .clk             (clk),
        .rst_n           (rst_n),
        .vid_req_n       (vid_req_n),
        .aud_req_n       (aud_req_n),
        .aud_serial_mode (aud_serial_mode),
        .vid_fifo_data   (vid_fifo_data),
        .vid_fifo_empty  (vid_fifo_empty),
        .vid_fifo_pop    (vid_fifo_pop),
        .aud_fifo_data   (aud_fifo_data),
        .aud_fifo_empty  (aud_fifo_empty),
        .aud_fifo_pop    (aud_fifo_pop),
        .ts_pending      (ts_pending),
        .dbus_out        (dbus_out),
        .dbus_oe         (dbus_oe),
        .vid_strb_n      (vid_strb_n),
        .aud_strb_n      (aud_strb_n),
        .aud_ser_out     (aud_ser_out),
        .ts_strb         (ts_strb)
    );
endmodule

// File: tb/strm_feed_port_tb_top.sv
module strm_feed_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QD = 512;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vid_req_n = 1'b1, aud_req_n = 1'b1, aud_serial_mode = 1'b0;
    logic frame_start0 = 1'b0, frame_start1 = 1'b0;
    logic [32:0] stc_value = '0;
    logic [7:0] vid_fifo_data, aud_fifo_data;
    logic vid_fifo_empty, aud_fifo_empty, vid_fifo_pop, aud_fifo_pop, ts_pending;
    logic [7:0] dbus_out;
    logic dbus_oe, vid_strb_n, aud_strb_n, aud_ser_out, ts_strb, stc_cap_stb;
    logic [32:0] stc_capture;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] vq [QD];
    logic       vmark [QD];
    logic [7:0] aq [QD];
    int vid_cnt = 0, vid_idx = 0, aud_cnt = 0, aud_idx = 0;
    int vrx = 0, arx = 0, abits = 0, cap_pulses = 0, nseq = 0, cyc = 0;
    logic [7:0] abuf = '0;
    logic seq [QD];
    int checks = 0, fails = 0;

    assign vid_fifo_empty = (vid_idx >= vid_cnt);
    assign aud_fifo_empty = (aud_idx >= aud_cnt);
    assign vid_fifo_data  = vid_fifo_empty ? 8'h00 : vq[vid_idx];
    assign aud_fifo_data  = aud_fifo_empty ? 8'h00 : aq[aud_idx];
    assign ts_pending     = vid_fifo_empty ? 1'b0 : vmark[vid_idx];

    strm_feed_port dut_i (
        .clk(clk), .rst_n(rst_n), .vid_req_n(vid_req_n), .aud_req_n(aud_req_n),
        .aud_serial_mode(aud_serial_mode),
        .vid_fifo_data(vid_fifo_data), .vid_fifo_empty(vid_fifo_empty), .vid_fifo_pop(vid_fifo_pop),
        .aud_fifo_data(aud_fifo_data), .aud_fifo_empty(aud_fifo_empty), .aud_fifo_pop(aud_fifo_pop),
        .ts_pending(ts_pending), .frame_start0(frame_start0), .frame_start1(frame_start1),
        .stc_value(stc_value), .dbus_out(dbus_out), .dbus_oe(dbus_oe),
        .vid_strb_n(vid_strb_n), .aud_strb_n(aud_strb_n), .aud_ser_out(aud_ser_out),
        .ts_strb(ts_strb), .stc_capture(stc_capture), .stc_cap_stb(stc_cap_stb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic alt_ok(input logic a, input logic b);
        return a != b;
    endfunction

    // FIFO model: pop consumes the head at the clock edge
    always @(posedge clk) begin
        if (vid_fifo_pop) vid_idx <= vid_idx + 1;
        if (aud_fifo_pop) aud_idx <= aud_idx + 1;
        if (vid_fifo_pop || aud_fifo_pop) begin
            seq[nseq] <= aud_fifo_pop;
            nseq <= nseq + 1;
        end
        cyc <= cyc + 1;
    end

    // Receiver model, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (stc_cap_stb) cap_pulses++;
            if (!vid_strb_n) begin
                chk(dbus_oe === 1'b1, "R2", "video bus enable", dbus_oe, 1);
                chk(dbus_out === vq[vrx], "R2", "video byte", dbus_out, vq[vrx]);
                chk(ts_strb === vmark[vrx], "R7", "timestamp marker", ts_strb, vmark[vrx]);
                vrx++;
            end
            if (!aud_strb_n) begin
                chk(ts_strb === 1'b0, "R7", "marker during audio", ts_strb, 0);
                if (aud_serial_mode) begin
                    chk(dbus_oe === 1'b0, "R3", "bus enable in serial", dbus_oe, 0);
                    abuf = {abuf[6:0], aud_ser_out};
                    abits++;
                    if (abits == 8) begin
                        chk(abuf === aq[arx], "R5", "serial byte msb first", abuf, aq[arx]);
                        arx++;
                        abits = 0;
                    end
                end else begin
                    chk(dbus_oe === 1'b1, "R4", "audio bus enable", dbus_oe, 1);
                    chk(dbus_out === aq[arx], "R4", "audio byte", dbus_out, aq[arx]);
                    arx++;
                end
            end
        end
    end

    task automatic push_v(input logic [7:0] b, input logic m);
        vq[vid_cnt] = b; vmark[vid_cnt] = m; vid_cnt++;
    endtask
    task automatic push_a(input logic [7:0] b);
        aq[aud_cnt] = b; aud_cnt++;
    endtask
    task automatic drain();
        vid_req_n = 1'b0; aud_req_n = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (vid_idx == vid_cnt && aud_idx == aud_cnt) break;
        end
        repeat (30) @(negedge clk);
        chk(vrx == vid_cnt, "R1", "all video delivered", vrx, vid_cnt);
        chk(arx == aud_cnt, "R1", "all audio delivered", arx, aud_cnt);
        chk(dbus_oe === 1'b0, "R3", "bus released when idle", dbus_oe, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > WATCHDOG) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(vid_strb_n === 1'b1 && aud_strb_n === 1'b1, "R10", "strobes idle", {vid_strb_n, aud_strb_n}, 3);
        chk(dbus_oe === 1'b0 && ts_strb === 1'b0 && aud_ser_out === 1'b0, "R10", "enable ts serial",
            {dbus_oe, ts_strb, aud_ser_out}, 0);
        chk(stc_capture === '0 && stc_cap_stb === 1'b0, "R10", "capture cleared", stc_capture, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty FIFO with request low starts nothing
        vid_req_n = 1'b0; aud_req_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(vid_strb_n === 1'b1 && aud_strb_n === 1'b1 && vrx == 0, "R1", "no transfer from empty", vrx, 0);
        // R1: data present but request high is ignored
        vid_req_n = 1'b1; aud_req_n = 1'b1;
        push_v(8'hA5, 1'b1); push_a(8'h3C);
        repeat (20) @(negedge clk);
        chk(vid_idx == 0 && aud_idx == 0 && vrx == 0 && arx == 0, "R1", "no pop without request", vid_idx + aud_idx, 0);
        drain();

        // R6: joint demand alternates
        vid_req_n = 1'b1; aud_req_n = 1'b1;
        aud_serial_mode = 1'b0;
        for (int i = 0; i < 4; i++) begin
            push_v(8'($urandom), 1'b0);
            push_a(8'($urandom));
        end
        begin
            int s0 = nseq;
            drain();
            for (int i = 1; i < 8; i++)
                chk(alt_ok(seq[s0 + i], seq[s0 + i - 1]), "R6", "round robin alternation",
                    seq[s0 + i], !seq[s0 + i - 1]);
        end

        // R5: serial audio, directed pattern then random
        aud_serial_mode = 1'b1;
        push_a(8'h81); push_a(8'h5A);
        push_v(8'h00, 1'b1);
        drain();

        // Random mixture with fixed seed
        for (int r = 0; r < 8; r++) begin
            vid_req_n = 1'b1; aud_req_n = 1'b1;
            aud_serial_mode = 1'($urandom);
            for (int i = 0; i < 1 + int'($urandom % 6); i++) push_v(8'($urandom), 1'($urandom));
            for (int i = 0; i < 1 + int'($urandom % 6); i++) push_a(8'($urandom));
            for (int c = 0; c < 80; c++) begin
                vid_req_n = 1'($urandom);
                aud_req_n = 1'($urandom);
                @(negedge clk);
            end
            drain();
        end

        // R8: capture on a frame-start rising edge, third clock edge later
        stc_value = 33'h1_2345_6789;
        cap_pulses = 0;
        frame_start0 = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(stc_cap_stb === 1'b0, "R8", "no capture before third edge", stc_cap_stb, 0);
        @(negedge clk);
        chk(stc_cap_stb === 1'b1, "R8", "capture pulse", stc_cap_stb, 1);
        chk(stc_capture === 33'h1_2345_6789, "R8", "captured value", stc_capture, 33'h1_2345_6789);
        stc_value = 33'h0_0000_0042;
        repeat (10) @(negedge clk);
        chk(stc_capture === 33'h1_2345_6789 && cap_pulses == 1, "R8", "level holds no capture",
            stc_capture, 33'h1_2345_6789);
        frame_start0 = 1'b0;
        repeat (6) @(negedge clk);
        // R9: simultaneous edges
        cap_pulses = 0;
        stc_value = 33'h0_ABCD_0001;
        frame_start0 = 1'b1; frame_start1 = 1'b1;
        repeat (12) @(negedge clk);
        chk(cap_pulses == 1, "R9", "single capture pulse", cap_pulses, 1);
        chk(stc_capture === 33'h0_ABCD_0001, "R9", "captured value", stc_capture, 33'h0_ABCD_0001);
        // R8: second input alone
        frame_start0 = 1'b0; frame_start1 = 1'b0;
        repeat (6) @(negedge clk);
        stc_value = 33'h1_0000_0007;
        frame_start1 = 1'b1;
        repeat (3) @(negedge clk);
        chk(stc_cap_stb === 1'b1 && stc_capture === 33'h1_0000_0007, "R8", "second input capture",
            stc_capture, 33'h1_0000_0007);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule